// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits beside a two-port memory array and watches the chip enable, read/write control and address of each port. When both ports are enabled and point at the same word, it picks one port as the winner and raises an active-low busy flag on the other port. While that port's busy flag is low, its write is held off through a per-port write-inhibit output that the array's write path must honour.

A mode input lets several of these blocks share one address space when memories are placed side by side to build a wider word. In master mode the block does its own arbitration and drives busy out. In slave mode it does no arbitration. It keeps its busy outputs inactive and takes a busy signal per port from the master instead. That incoming busy flag alone decides which writes are inhibited, so every device in the group suppresses the same port.

The model is synchronous. A match is registered before busy goes low, and a mismatch is registered before busy returns high.

Top module: `addr_busy_arb`

## Requirements
- R1: During and straight after reset, both busy outputs are high (inactive) and both write-inhibit outputs are low.
- R2: In master mode (`slave_mode`=0), when both chip enables are low and both addresses are equal at a clock edge, the losing port's busy goes low one clock later.
- R3: In master mode, busy returns high one clock after the first edge at which the match no longer holds.
- R4: Equal addresses give no busy while either chip enable is high.
- R5: When a match starts, the port whose chip enable has been low for more cycles wins, and the other port loses.
- R6: When both chip enables went low in the same cycle, or have both been low for the same number of cycles, the left port wins.
- R7: While the match continues, the winner stays the same whatever either port does with its read/write line.
- R8: In master mode a port's write-inhibit is high exactly when that port has busy low, its chip enable is low and its read/write input is 0 (0 = write, 1 = read). Reads are never inhibited.
- R9: In slave mode both busy outputs stay high. Each port's write-inhibit is high exactly when its busy input is low, its chip enable is low and its read/write is 0, whether or not the addresses match.
- R10: In master mode the busy inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 0 = master (arbitrate, drive busy), 1 = slave (accept busy) |
| l_ce_n | input | 1 | Left port chip enable, active low |
| l_rw | input | 1 | Left port read/write, 1 = read, 0 = write |
| l_addr | input | AW | Left port address |
| l_busy_in_n | input | 1 | Left busy from master device, used in slave mode |
| r_ce_n | input | 1 | Right port chip enable, active low |
| r_rw | input | 1 | Right port read/write, 1 = read, 0 = write |
| r_addr | input | AW | Right port address |
| r_busy_in_n | input | 1 | Right busy from master device, used in slave mode |
| l_busy_n | output | 1 | Left busy, active low |
| r_busy_n | output | 1 | Right busy, active low |
| l_wr_inhibit | output | 1 | Suppress the left port's write |
| r_wr_inhibit | output | 1 | Suppress the right port's write |

## Verification
The assertions take for granted that an enabled port changes its address only in a cycle where its read/write line is high (read), and that the mode input only changes while both ports are idle. The timing properties also assume that a matching pair of addresses holds for the cycle being checked. The stimulus sets read/write high in any cycle where it moves an address, and this holds for the random phase too. It switches mode only after both enables have been high for several cycles.

// File: rtl/addr_busy_arb.sv
module addr_busy_arb #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          l_ce_n,
  input  logic          l_rw,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_in_n,
  input  logic          r_ce_n,
  input  logic          r_rw,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_inhibit,
  output logic          r_wr_inhibit
);

  logic l_on, r_on, hit;
  logic lock_q, win_r_q, r_older_q;
  logic l_lose, r_lose, l_block, r_block;

  assign l_on = ~l_ce_n;
  assign r_on = ~r_ce_n;
  assign hit  = l_on & r_on & (l_addr == r_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      win_r_q   <= 1'b0;
      r_older_q <= 1'b0;
    end else begin
      lock_q <= hit;
      if (hit && !lock_q) win_r_q <= r_older_q;
      if (!r_on)      r_older_q <= 1'b0;
      else if (!l_on) r_older_q <= 1'b1;
    end
  end

  assign l_lose = lock_q & win_r_q;
  assign r_lose = lock_q & ~win_r_q;

  assign l_busy_n = slave_mode | ~l_lose;
  assign r_busy_n = slave_mode | ~r_lose;

  assign l_block = slave_mode ? ~l_busy_in_n : l_lose;
  assign r_block = slave_mode ? ~r_busy_in_n : r_lose;

  assign l_wr_inhibit = l_on & ~l_rw & l_block;
  assign r_wr_inhibit = r_on & ~r_rw & r_block;

endmodule

// File: rtl/addr_busy_arb_chk.sv
module addr_busy_arb_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_mode,
  input logic          l_ce_n,
  input logic          l_rw,
  input logic [AW-1:0] l_addr,
  input logic          r_ce_n,
  input logic          r_rw,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_wr_inhibit,
  input logic          r_wr_inhibit
);
  logic same;
  assign same = !l_ce_n && !r_ce_n && (l_addr == r_addr);

  assert_busy_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!slave_mode) && (!l_busy_n || !r_busy_n)) |-> $past(same));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!same)) |-> (l_busy_n && r_busy_n));

  assert_single_loser_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~l_busy_n, ~r_busy_n}) <= 1);

  assert_winner_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!slave_mode) && $past(same) && $past(!l_busy_n)) |-> !l_busy_n);

  assert_read_never_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rw || l_ce_n) |-> !l_wr_inhibit);

  assert_read_never_blocked_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rw || r_ce_n) |-> !r_wr_inhibit);

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (l_busy_n && r_busy_n));

  assert_addr_move_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && $past(!l_ce_n) && (l_addr != $past(l_addr))) |-> l_rw);
endmodule

bind addr_busy_arb addr_busy_arb_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
  .l_ce_n(l_ce_n), .l_rw(l_rw), .l_addr(l_addr),
  .r_ce_n(r_ce_n), .r_rw(r_rw), .r_addr(r_addr),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_inhibit(l_wr_inhibit), .r_wr_inhibit(r_wr_inhibit)
);

// File: tb/addr_busy_arb_test.sv
module addr_busy_arb_test;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0, slave_mode = 0;
  logic l_ce_n = 1, l_rw = 1, l_busy_in_n = 1;
  logic r_ce_n = 1, r_rw = 1, r_busy_in_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_n, r_busy_n, l_wr_inhibit, r_wr_inhibit;

  always #2.5 clk = ~clk;

  addr_busy_arb #(.AW(AW)) uut (.*);

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  // reference model: ages of enables, lock flag, winner
  int l_age = 0, r_age = 0;
  bit lock = 0, win_right = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_age = 0; r_age = 0; lock = 0; win_right = 0;
    end else begin
      bit m;
      m = !l_ce_n && !r_ce_n && (l_addr == r_addr);
      if (m && !lock) win_right = (r_age > l_age);
      lock = m;
      l_age = !l_ce_n ? l_age + 1 : 0;
      r_age = !r_ce_n ? r_age + 1 : 0;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit lb, rb, eli, eri;
    lb = !slave_mode && lock && win_right;
    rb = !slave_mode && lock && !win_right;
    eli = !l_ce_n && !l_rw && (slave_mode ? !l_busy_in_n : lb);
    eri = !r_ce_n && !r_rw && (slave_mode ? !r_busy_in_n : rb);
    chk("l_busy_n", l_busy_n, !lb);
    chk("r_busy_n", r_busy_n, !rb);
    chk("l_wr_inhibit", l_wr_inhibit, eli);
    chk("r_wr_inhibit", r_wr_inhibit, eri);
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle();
    l_ce_n = 1; r_ce_n = 1; l_rw = 1; r_rw = 1;
    cyc(3);
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    cyc(3); rst_n = 1; cyc(2);

    // R4: equal address with one side disabled
    phase = "R4";
    l_addr = 5; r_addr = 5; l_ce_n = 0; l_rw = 0; cyc(3);
    l_ce_n = 1; r_ce_n = 0; r_rw = 0; cyc(3);
    idle();

    // R6 + R2 + R8: both enabled in same cycle, both writing; left wins
    phase = "R6";
    l_addr = 7; r_addr = 7; l_ce_n = 0; r_ce_n = 0; l_rw = 0; r_rw = 0; cyc(1);
    phase = "R2"; cyc(1);
    phase = "R8"; cyc(2);
    r_rw = 1; cyc(1); r_rw = 0; cyc(1);
    // R3: move right address away (read while moving)
    phase = "R3";
    r_rw = 1; cyc(1); r_addr = 8; cyc(1); r_rw = 0; cyc(2);
    idle();

    // R5: right enabled first, left joins; left loses
    phase = "R5";
    r_addr = 9; r_ce_n = 0; r_rw = 1; cyc(3);
    l_addr = 9; l_ce_n = 0; l_rw = 0; cyc(3);
    // R7: rw activity on both sides keeps the winner
    phase = "R7";
    r_rw = 0; cyc(2); l_rw = 1; cyc(1); l_rw = 0; r_rw = 1; cyc(2);
    // loser drops and retries at same address: right still older
    l_ce_n = 1; cyc(2); l_ce_n = 0; cyc(3);
    idle();

    // R6: both already enabled, addresses converge with equal ages
    phase = "R6";
    l_addr = 1; r_addr = 2; l_ce_n = 0; r_ce_n = 0; cyc(2);
    r_addr = 1; cyc(1); r_rw = 0; cyc(2);
    idle();

    // R10: master ignores busy inputs
    phase = "R10";
    l_busy_in_n = 0; r_busy_in_n = 0;
    l_addr = 3; r_addr = 4; l_ce_n = 0; r_ce_n = 0; l_rw = 0; r_rw = 0; cyc(3);
    l_busy_in_n = 1; r_busy_in_n = 1;
    idle();

    // R9: slave mode follows busy inputs only
    phase = "R9";
    slave_mode = 1; cyc(1);
    l_addr = 6; r_addr = 6; l_ce_n = 0; r_ce_n = 0; l_rw = 0; r_rw = 0; cyc(3);
    r_busy_in_n = 0; cyc(2);
    l_busy_in_n = 0; r_busy_in_n = 1; cyc(2);
    l_rw = 1; cyc(1);
    l_ce_n = 1; r_busy_in_n = 0; cyc(2);
    l_busy_in_n = 1; r_busy_in_n = 1;
    idle();
    slave_mode = 0; cyc(2);

    // R2/R3/R5: random traffic over a small address range
    phase = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] na;
      l_ce_n = ($urandom % 5) == 0;
      r_ce_n = ($urandom % 5) == 0;
      na = AW'($urandom % 3);
      l_rw = $urandom % 2;
      if (na != l_addr) l_rw = 1;
      l_addr = na;
      na = AW'($urandom % 3);
      r_rw = $urandom % 2;
      if (na != r_addr) r_rw = 1;
      r_addr = na;
      l_busy_in_n = $urandom % 2;
      r_busy_in_n = $urandom % 2;
      cyc(1);
    end
    idle();
    finish_run();
  end
endmodule